// File: doc/BRIEF.md
# Double to int32 modular converter

The block takes a 64-bit IEEE-754 double-precision operand and turns it into a 32-bit signed integer. The conversion always rounds toward zero. The integer part is then reduced modulo 2^32, so an operand beyond the int32 range wraps and does not clamp. The exception flags are judged as a saturating conversion would judge them. An operand whose truncated value lies outside [-2^31, 2^31-1] raises invalid. An in-range operand that loses fractional bits raises inexact. Invalid always suppresses inexact.

An operand is presented with a valid strobe. The result and both flags appear on registered outputs one clock later, together with an output valid. A new operand may be accepted on every cycle. Collecting the flags into any status store is left to the surrounding pipeline.

Top module: `dbl2i32_wrap`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high, so that a result follows every accepted operand after one clock. An idle input gives an idle output.
- R2: A finite operand whose truncated value lies within [-2^31, 2^31-1] and has no fractional part gives that value in two's complement on `out_result`, with both flags low.
- R3: A finite in-range operand with a nonzero discarded fraction raises `out_inexact` and not `out_invalid`. This covers normal magnitudes below 1.0 and every nonzero subnormal, which give result 0.
- R4: A finite operand whose truncated integer lies outside the int32 range gives the low 32 bits of that integer in two's complement. A negative value is negated before the low bits are taken.
- R5: Invalid is raised when the unbiased exponent is above 31. It is also raised when the truncated magnitude exceeds 0x7FFFFFFF for a positive operand, or 0x80000000 for a negative one. An exponent of exactly 31 alone does not raise invalid, so -2^31 and -2147483648.5 are not invalid.
- R6: Whenever invalid is raised, inexact is low, even when fractional bits were discarded. For example, operand 0xC1EE9B7E5FC9EBA4 gives invalid=1 and inexact=0.
- R7: NaN and both infinities (exponent field all ones) give result 0 and invalid, with inexact low.
- R8: A finite operand with unbiased exponent of 84 or more gives result 0 and invalid, because no integer bit below 2^32 is set.
- R9: Positive and negative zero give result 0 with both flags low.
- R10: While `rst_n` is low at a clock edge, all outputs are driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | Double-precision operand (sign bit 63, exponent bits 62:52, fraction bits 51:0) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Truncated integer modulo 2^32 |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
Range overflow and fraction loss can both be present in the same operand. Examples are 2^31+0.5 and 0xC1EE9B7E5FC9EBA4. For these, the invalid verdict has to win over the inexact one in the same output cycle.

The bench drives such operands back to back, mixed with operands that sit on the boundary. These include exactly -2^31, -2^31-0.5 (truncates into range) and -2^31-1. Each cycle's flag pair is compared against a behavioural model built on 128-bit integers. A checker property also forbids both flags being high together on any valid output.

// File: rtl/d2i_pkg.sv
`timescale 1ns/1ps
// Package: shared format constants and types for the double-to-int converter.
// Assumes IEEE-754 binary64 operands.
package d2i_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int BIAS   = 1023;
    localparam int OP_W   = 1 + EXP_W + FRAC_W;
    localparam int UE_W   = EXP_W + 2;   // signed unbiased exponent width

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fclass_e;

    typedef struct packed {
        logic                   sign;
        fclass_e                cls;
        logic signed [UE_W-1:0] uexp;
        logic [FRAC_W:0]        mant;
    } fp_fields_t;
endpackage

// File: rtl/d2i_unpack.sv
`timescale 1ns/1ps
// Module: d2i_unpack
// Splits a binary64 operand into sign, class, unbiased exponent and
// significand with the hidden bit restored. Purely combinational.
// Assumes the operand layout sign | exponent | fraction.
module d2i_unpack
    import d2i_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output fp_fields_t      fields
);
    localparam logic [EXP_W-1:0]        EXP_ALL1 = '1;
    localparam logic [EXP_W-1:0]        EXP_ZERO = '0;
    localparam logic signed [UE_W-1:0]  BIAS_S   = UE_W'(BIAS);

    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;

    assign exp_field  = op[OP_W-2 -: EXP_W];
    assign frac_field = op[FRAC_W-1:0];

    // Classify the operand and restore the hidden significand bit.
    always_comb begin
        fields.sign = op[OP_W-1];
        fields.uexp = $signed({2'b00, exp_field}) - BIAS_S;
        fields.mant = {1'b1, frac_field};
        if (exp_field == EXP_ALL1) begin
            fields.cls  = (frac_field == '0) ? CLS_INF : CLS_NAN;
            fields.mant = '0;
        end else if (exp_field == EXP_ZERO) begin
            fields.cls  = (frac_field == '0) ? CLS_ZERO : CLS_SUB;
            fields.mant = {1'b0, frac_field};
        end else begin
            fields.cls  = CLS_NORM;
        end
    end
endmodule

// File: rtl/d2i_align.sv
`timescale 1ns/1ps
// Module: d2i_align
// Moves the significand so that its binary point sits below bit 0.
// Returns the low INT_W bits of the truncated magnitude and whether fraction
// bits were dropped. It also reports whether the magnitude needs more than
// INT_W bits. Combinational. Assumes INT_W < FRAC_W.
module d2i_align
    import d2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  fclass_e                cls,
    input  logic signed [UE_W-1:0] uexp,
    input  logic [FRAC_W:0]        mant,
    output logic [INT_W-1:0]       mag,
    output logic                   lost,
    output logic                   exp_over
);
    localparam int WIDE_W = FRAC_W + 1 + INT_W;
    localparam int SH_W   = $clog2(WIDE_W + 1);
    localparam logic signed [UE_W-1:0] UE_ZERO = '0;
    localparam logic signed [UE_W-1:0] UE_FRAC = UE_W'(FRAC_W);
    localparam logic signed [UE_W-1:0] UE_WIPE = UE_W'(FRAC_W + INT_W);

    logic [WIDE_W-1:0] mant_ext;
    logic [WIDE_W-1:0] wide;
    logic [SH_W-1:0]   rsh;
    logic [SH_W-1:0]   lsh;
    logic              far_out;

    assign mant_ext = {{INT_W{1'b0}}, mant};
    assign rsh      = SH_W'(FRAC_W) - uexp[SH_W-1:0];
    assign lsh      = uexp[SH_W-1:0] - SH_W'(FRAC_W);
    assign far_out  = (cls == CLS_NORM) && (uexp >= UE_WIPE);

    // Shift toward the integer point and detect discarded fraction bits.
    always_comb begin
        wide = '0;
        lost = 1'b0;
        if (cls == CLS_SUB) begin
            lost = 1'b1;
        end else if (cls == CLS_NORM) begin
            if (uexp < UE_ZERO) begin
                lost = 1'b1;
            end else if (uexp <= UE_FRAC) begin
                wide = mant_ext >> rsh;
                lost = ((wide << rsh) != mant_ext);
            end else if (uexp < UE_WIPE) begin
                wide = mant_ext << lsh;
            end
        end
    end

    assign mag      = wide[INT_W-1:0];
    assign exp_over = (|wide[WIDE_W-1:INT_W]) || far_out;
endmodule

// File: rtl/d2i_flags.sv
`timescale 1ns/1ps
// Module: d2i_flags
// Applies the sign and wraps the result modulo 2^INT_W. Judges the invalid
// flag against the true signed INT_W range and suppresses inexact under
// invalid. Combinational.
module d2i_flags
    import d2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             sign,
    input  fclass_e          cls,
    input  logic [INT_W-1:0] mag,
    input  logic             lost,
    input  logic             exp_over,
    output logic [INT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MAG = {1'b1, {(INT_W-1){1'b0}}};

    logic special;
    logic range_bad;

    assign special   = (cls == CLS_NAN) || (cls == CLS_INF);
    assign range_bad = exp_over || (sign ? (mag > NEG_MAG) : (mag > POS_MAX));

    // Form the wrapped result and the prioritised flag pair.
    always_comb begin
        invalid = special || range_bad;
        inexact = lost && !invalid;
        if (special) result = '0;
        else         result = sign ? (~mag + 1'b1) : mag;
    end
endmodule

// File: rtl/dbl2i32_wrap.sv
`timescale 1ns/1ps
// Module: dbl2i32_wrap (top)
// Converts a binary64 operand to an INT_W-bit integer: it truncates toward
// zero and wraps modulo 2^INT_W. Flags follow a saturating conversion.
// Single register stage: outputs are valid one cycle after in_valid.
// Assumes a synchronous, active-low reset.
module dbl2i32_wrap
    import d2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  in_operand,
    output logic             out_valid,
    output logic [INT_W-1:0] out_result,
    output logic             out_invalid,
    output logic             out_inexact
);
    fp_fields_t       fields;
    logic [INT_W-1:0] mag;
    logic             lost;
    logic             exp_over;
    logic [INT_W-1:0] res_c;
    logic             inv_c;
    logic             inx_c;

    d2i_unpack u_unpack (
        .op     (in_operand),
        .fields (fields)
    );

    d2i_align #(.INT_W(INT_W)) u_align (
        .cls      (fields.cls),
        .uexp     (fields.uexp),
        .mant     (fields.mant),
        .mag      (mag),
        .lost     (lost),
        .exp_over (exp_over)
    );

    d2i_flags #(.INT_W(INT_W)) u_flags (
        .sign     (fields.sign),
        .cls      (fields.cls),
        .mag      (mag),
        .lost     (lost),
        .exp_over (exp_over),
        .result   (res_c),
        .invalid  (inv_c),
        .inexact  (inx_c)
    );

    // Register the result and flags for each accepted operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result  <= res_c;
                out_invalid <= inv_c;
                out_inexact <= inx_c;
            end
        end
    end
endmodule

// File: rtl/dbl2i32_wrap_chk.sv
`timescale 1ns/1ps
// Module: dbl2i32_wrap_chk
// Port-level properties of the converter, bound to every instance of the top.
module dbl2i32_wrap_chk
    import d2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [OP_W-1:0]  in_operand,
    input logic             out_valid,
    input logic [INT_W-1:0] out_result,
    input logic             out_invalid,
    input logic             out_inexact
);
    localparam logic [EXP_W-1:0] E_ALL1 = '1;
    localparam logic [EXP_W-1:0] E_ONE  = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] E_OVER = EXP_W'(BIAS + INT_W);
    localparam logic [EXP_W-1:0] E_WIPE = EXP_W'(BIAS + FRAC_W + INT_W);

    logic [EXP_W-1:0] ef;
    assign ef = in_operand[OP_W-2 -: EXP_W];

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r6_invalid_wins: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));
    a_r7_special_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ef == E_ALL1) |=> (out_invalid && !out_inexact && out_result == '0));
    a_r5_exp_over: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ef >= E_OVER && ef != E_ALL1) |=> (out_invalid && !out_inexact));
    a_r8_far_exponent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ef >= E_WIPE && ef != E_ALL1) |=> (out_result == '0));
    a_r3_small_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ef < E_ONE && in_operand[OP_W-2:0] != '0)
        |=> (out_result == '0 && out_inexact && !out_invalid));
    a_r9_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_operand[OP_W-2:0] == '0)
        |=> (out_result == '0 && !out_inexact && !out_invalid));
endmodule

bind dbl2i32_wrap dbl2i32_wrap_chk #(.INT_W(INT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_operand  (in_operand),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid),
    .out_inexact (out_inexact)
);

// File: tb/dbl2i32_wrap_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural 128-bit reference model, compared on every clock.
module dbl2i32_wrap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_invalid;
    logic        out_inexact;

    int    checks = 0;
    int    errors = 0;
    bit    mon_en = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R2";
    logic        prev_v = 1'b0;
    logic [63:0] prev_op = '0;
    string       prev_tag = "R2";

    dbl2i32_wrap dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact)
    );

    always #4 clk = ~clk;

    function automatic void model(input logic [63:0] op, output logic [31:0] r,
                                  output logic inv, output logic inx);
        int ex;
        int sh;
        logic [127:0] mant;
        logic [127:0] mag;
        logic lost;
        logic big;
        ex = int'(op[62:52]);
        mant = {75'd0, (ex != 0), op[51:0]};
        r = '0; inv = 1'b0; inx = 1'b0;
        if (ex == 2047) begin inv = 1'b1; return; end
        if (ex == 0 && op[51:0] == '0) return;
        sh = ((ex == 0) ? 1 : ex) - 1075;
        big = (ex - 1023) >= 64;
        lost = 1'b0;
        if (sh >= 0) mag = (sh >= 75) ? '0 : (mant << sh);
        else if (-sh >= 53) begin mag = '0; lost = 1'b1; end
        else begin
            mag = mant >> (-sh);
            lost = (mant & ((128'd1 << (-sh)) - 128'd1)) != '0;
        end
        inv = big || (!op[63] && mag > 128'h7FFFFFFF) || (op[63] && mag > 128'h80000000);
        if (op[63]) mag = ~mag + 128'd1;
        r = mag[31:0];
        inx = !inv && lost;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Record what the design saw at each edge.
    always @(posedge clk) begin
        prev_v   <= in_valid & rst_n;
        prev_op  <= in_operand;
        prev_tag <= cur_tag;
    end

    // Compare registered outputs with the model in the middle of each cycle.
    always @(negedge clk) begin
        logic [31:0] er;
        logic ei;
        logic ex;
        if (mon_en) begin
            chk("R1", "out_valid", 64'(out_valid), 64'(prev_v));
            if (prev_v) begin
                model(prev_op, er, ei, ex);
                chk(prev_tag, $sformatf("result op=%h", prev_op), 64'(out_result), 64'(er));
                chk(prev_tag, $sformatf("invalid op=%h", prev_op), 64'(out_invalid), 64'(ei));
                chk(prev_tag, $sformatf("inexact op=%h", prev_op), 64'(out_inexact), 64'(ex));
            end
        end
    end

    task automatic send(input logic [63:0] op, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_operand = op;
        cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        in_operand = 64'h3FF0000000000000;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "reset out_valid", 64'(out_valid), 64'd0);
        chk("R10", "reset out_result", 64'(out_result), 64'd0);
        chk("R10", "reset flags", 64'({out_invalid, out_inexact}), 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        mon_en = 1'b1;
        idle(2);
        // R2 exact in-range values
        send(64'h3FF0000000000000, "R2");
        send(64'hBFF0000000000000, "R2");
        send(64'h41DFFFFFFFC00000, "R2");
        send(64'h4059000000000000, "R2");
        // R3 fraction discarded in range
        send(64'h3FF8000000000000, "R3");
        send(64'hC004000000000000, "R3");
        send(64'h3FE0000000000000, "R3");
        send(64'h0000000000000001, "R3");
        send(64'h800FFFFFFFFFFFFF, "R3");
        // R5 boundary around -2^31 and +2^31
        send(64'hC1E0000000000000, "R5");
        send(64'hC1E0000000100000, "R5");
        send(64'hC1E0000000200000, "R5");
        send(64'h41E0000000000000, "R5");
        // R6 invalid suppresses inexact
        send(64'hC1EE9B7E5FC9EBA4, "R6");
        send(64'h41E0000000100000, "R6");
        // R4 wrapping beyond range
        send(64'h41F0000000500000, "R4");
        send(64'h4520000000000001, "R4");
        send(64'hC1F0000000500000, "R4");
        // R8 far exponent
        send(64'h4530000000000000, "R8");
        send(64'h7E37E43C8800759C, "R8");
        // R7 specials
        send(64'h7FF0000000000000, "R7");
        send(64'hFFF0000000000000, "R7");
        send(64'h7FF8000000000001, "R7");
        // R9 zeros
        send(64'h0000000000000000, "R9");
        send(64'h8000000000000000, "R9");
        idle(3);
        // R4 random operands near the range edges, with idle gaps (R1)
        for (int k = 0; k < 600; k++) begin
            logic [63:0] op;
            op = {$urandom, $urandom};
            op[62:52] = 11'(1020 + ($urandom % 70));
            if (($urandom % 5) == 0) idle(1);
            send(op, "R4");
        end
        idle(3);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule